// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address stream of a synchronous DRAM burst. A mode-load strobe captures a small control word that sets three things: how many columns a burst covers, whether the addresses wrap sequentially or follow an XOR pattern, and whether writes burst or are always single accesses. A start strobe with a starting column then makes the block issue one column per clock on `col_o`, with `valid_o` for every beat and `last_o` on the final beat of a finite burst.

Full-page bursts run around the entire 2^COL_W column page until `term_i` ends them. A start strobe during a burst cuts it short and begins the new one straight away. A mode load is accepted only while no burst is running. Illegal settings are reported and reduced to single-beat bursts. Row, bank, command timing and data are handled elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: On `mrs_i` while idle, `mode_i` is stored: bits [2:0] give the length code (000=1, 001=2, 010=4, 011=8, 111=full page), bit 3 selects the order (0 sequential, 1 interleaved), bit 4 set selects single-access writes. The stored word governs bursts started at later clock edges. A start in the same cycle as the load uses the previous word.
- R2: In sequential order, beat n of a burst of length L from column S is (S with its low log2(L) bits cleared) plus ((S + n) mod L).
- R3: In interleaved order, beat n is S with its low log2(L) bits replaced by (S xor n) in those bits.
- R4: A full page burst in sequential order emits S, S+1, ... modulo 2^COL_W, never raises `last_o`, and ends after the beat during which `term_i` is high. `term_i` has no effect on finite bursts.
- R5: Length codes 100, 101 and 110, and full page combined with interleaved order, drive `mode_err_o` high while stored, and bursts are then one beat long.
- R6: With bit 4 set, a write start (`wr_i`=1) gives a one-beat burst, and read starts use the programmed length. With bit 4 clear, writes use the programmed length.
- R7: A finite burst gives exactly L beats. `last_o` is high with the final beat only, including for L=1, and `valid_o` is low in the following cycle unless a new burst starts.
- R8: `start_i` during a burst abandons it, and the first beat of the new burst appears in the next cycle.
- R9: `mrs_i` during a burst leaves the stored word unchanged and makes `mrs_err_o` high for exactly the following cycle.
- R10: After reset `valid_o`, `last_o`, `mrs_err_o` and `mode_err_o` are low and the stored word is length 1, sequential, writes bursting.
- R11: The first beat, equal to `col_i`, appears in the cycle after `start_i`, and later beats follow one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mrs_i | input | 1 | Mode load strobe |
| mode_i | input | 5 | Mode word: length code, order, write mode |
| start_i | input | 1 | Burst start strobe |
| wr_i | input | 1 | Start is a write (1) or read (0) |
| col_i | input | COL_W | Starting column |
| term_i | input | 1 | Ends a full-page burst |
| col_o | output | COL_W | Current column |
| valid_o | output | 1 | Column beat valid |
| last_o | output | 1 | Final beat of a finite burst |
| mode_err_o | output | 1 | Stored mode word is illegal |
| mrs_err_o | output | 1 | Mode load was refused because a burst was running |

## Verification
Two functions can fall in the same cycle. A mode load can coincide with a start while the block is idle. The bench drives both strobes on one edge and expects the burst to follow the old length, with the next burst following the new one. A new start can also land on the final beat of a burst. In that case the bench expects the new burst's first column in the very next cycle, with no idle gap. It also drives a refused mode load in the middle of a running burst and expects the beats to continue unchanged.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int MODE_W = 5;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic       single_wr;
    logic       ilv;
    logic [2:0] len_code;
  } mode_t;
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrs_i,
  input  logic              busy_i,
  input  logic [MODE_W-1:0] mode_i,
  output mode_t             mode_o,
  output logic              mrs_err_o
);
  mode_t mode_q;
  logic  err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= mrs_i & busy_i;
      if (mrs_i && !busy_i) mode_q <= mode_t'(mode_i);
    end
  end

  assign mode_o    = mode_q;
  assign mrs_err_o = err_q;
endmodule

// File: rtl/burst_len_dec.sv
module burst_len_dec
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  mode_t            mode_i,
  input  logic             wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             cfg_err_o
);
  logic [COL_W-1:0] code_mask;
  logic             page_req;
  logic             reserved;

  always_comb begin
    code_mask = '0;
    page_req  = 1'b0;
    reserved  = 1'b0;
    case (mode_i.len_code)
      LEN_1:    code_mask = '0;
      LEN_2:    code_mask = COL_W'(1);
      LEN_4:    code_mask = COL_W'(3);
      LEN_8:    code_mask = COL_W'(7);
      LEN_PAGE: begin code_mask = '1; page_req = 1'b1; end
      default:  reserved = 1'b1;
    endcase
  end

  assign cfg_err_o = reserved | (page_req & mode_i.ilv);

  always_comb begin
    if (cfg_err_o || (mode_i.single_wr && wr_i)) begin
      mask_o = '0;
      full_o = 1'b0;
    end else begin
      mask_o = code_mask;
      full_o = page_req;
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_sum;
  logic [COL_W-1:0] ilv_val;

  assign seq_sum = base_i + idx_i;
  assign ilv_val = base_i ^ idx_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? (ilv_i ? ilv_val[b] : seq_sum[b]) : base_i[b];
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl #(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] idx_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o
);
  logic             active_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, idx_q, mask_q;
  logic             at_end;

  assign at_end = (idx_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      full_q   <= full_i;
      ilv_q    <= ilv_i;
      base_q   <= col_i;
      idx_q    <= '0;
      mask_q   <= mask_i;
    end else if (active_q) begin
      if (full_q ? term_i : at_end) active_q <= 1'b0;
      else                          idx_q    <= idx_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign last_o   = active_q & ~full_q & at_end;
  assign base_o   = base_q;
  assign idx_o    = idx_q;
  assign mask_o   = mask_q;
  assign ilv_o    = ilv_q;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrs_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              mode_err_o,
  output logic              mrs_err_o
);
  mode_t            mode_q;
  logic [COL_W-1:0] dec_mask, cur_base, cur_idx, cur_mask;
  logic             dec_full, cur_ilv, active;

  burst_mode_reg u_mode (
    .clk_i, .rst_ni, .mrs_i,
    .busy_i    (active),
    .mode_i,
    .mode_o    (mode_q),
    .mrs_err_o
  );

  burst_len_dec #(.COL_W(COL_W)) u_dec (
    .mode_i    (mode_q),
    .wr_i,
    .mask_o    (dec_mask),
    .full_o    (dec_full),
    .cfg_err_o (mode_err_o)
  );

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .term_i, .col_i,
    .mask_i   (dec_mask),
    .full_i   (dec_full),
    .ilv_i    (mode_q.ilv),
    .active_o (active),
    .last_o,
    .base_o   (cur_base),
    .idx_o    (cur_idx),
    .mask_o   (cur_mask),
    .ilv_o    (cur_ilv)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (cur_base),
    .idx_i  (cur_idx),
    .mask_i (cur_mask),
    .ilv_i  (cur_ilv),
    .col_o
  );

  assign valid_o = active;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mrs_i,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             mode_err_o,
  input logic             mrs_err_o
);
  assert_last_has_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  assert_burst_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o);

  assert_first_beat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && (col_o == $past(col_i)));

  assert_busy_load_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_i && valid_o |=> mrs_err_o);

  assert_busy_load_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> $stable(mode_err_o));

  assert_flag_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_err_o |-> $past(mrs_i));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mrs_i(mrs_i), .start_i(start_i),
  .col_i(col_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o),
  .mode_err_o(mode_err_o), .mrs_err_o(mrs_err_o)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  localparam int COL_W = 10;
  localparam int PAGE  = 1 << COL_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             mrs_i = 1'b0;
  logic [4:0]       mode_i = '0;
  logic             start_i = 1'b0;
  logic             wr_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic             term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, mode_err_o, mrs_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int n, int len, bit ilv);
    int m = len - 1;
    int lo = ilv ? ((s ^ n) & m) : ((s + n) & m);
    return ((s & ~m) | lo) & (PAGE - 1);
  endfunction

  task automatic beat(input int exp, input bit exp_last, input string req);
    chk(valid_o === 1'b1, req, int'(valid_o), 1);
    chk(col_o === COL_W'(exp), req, int'(col_o), exp);
    chk(last_o === exp_last, req, int'(last_o), int'(exp_last));
  endtask

  task automatic set_mode(input logic [4:0] m);
    @(negedge clk_i); mrs_i = 1'b1; mode_i = m;
    @(negedge clk_i); mrs_i = 1'b0;
  endtask

  task automatic run_burst(input bit wr, input int s, input int len, input bit ilv, input string req);
    @(negedge clk_i); start_i = 1'b1; wr_i = wr; col_i = COL_W'(s);
    @(negedge clk_i); start_i = 1'b0;
    for (int i = 0; i < len; i++) begin
      beat(exp_col(s, i, len, ilv), i == len - 1, req);
      @(negedge clk_i);
    end
    chk(valid_o === 1'b0, req, int'(valid_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(valid_o === 0 && last_o === 0, "R10", int'(valid_o), 0);
    chk(mode_err_o === 0 && mrs_err_o === 0, "R10", int'(mode_err_o), 0);
    rst_ni = 1'b1;
    run_burst(0, 13, 1, 0, "R10");

    // R1 R2 R3 R7 R11 sweep over lengths, orders and start columns
    for (int code = 0; code < 4; code++)
      for (int ilv = 0; ilv < 2; ilv++) begin
        set_mode({1'b0, ilv[0], code[2:0]});
        chk(mode_err_o === 0, "R1", int'(mode_err_o), 0);
        for (int s = 0; s < 16; s++)
          run_burst(s[0], (s * 67) % PAGE, 1 << code, ilv[0], ilv ? "R3" : "R2");
      end

    // R4 full page wraps, terminates, no last
    set_mode(5'b00111);
    @(negedge clk_i); start_i = 1'b1; wr_i = 0; col_i = COL_W'(1020);
    @(negedge clk_i); start_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      beat((1020 + i) % PAGE, 1'b0, "R4");
      if (i == 9) term_i = 1'b1;
      @(negedge clk_i);
      term_i = 1'b0;
    end
    chk(valid_o === 1'b0, "R4", int'(valid_o), 0);

    // R4 term has no effect on a finite burst
    set_mode(5'b00010);
    @(negedge clk_i); start_i = 1'b1; col_i = COL_W'(9);
    @(negedge clk_i); start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      beat(exp_col(9, i, 4, 0), i == 3, "R4");
      term_i = 1'b1;
      @(negedge clk_i);
      term_i = 1'b0;
    end
    chk(valid_o === 1'b0, "R4", int'(valid_o), 0);

    // R5 illegal settings
    for (int c = 4; c < 7; c++) begin
      set_mode({2'b00, c[2:0]});
      chk(mode_err_o === 1'b1, "R5", int'(mode_err_o), 1);
      run_burst(0, 77, 1, 0, "R5");
    end
    set_mode(5'b01111);
    chk(mode_err_o === 1'b1, "R5", int'(mode_err_o), 1);
    run_burst(0, 300, 1, 0, "R5");

    // R6 single-access writes
    set_mode(5'b10010);
    chk(mode_err_o === 1'b0, "R6", int'(mode_err_o), 0);
    run_burst(1, 22, 1, 0, "R6");
    run_burst(0, 22, 4, 0, "R6");
    set_mode(5'b00010);
    run_burst(1, 22, 4, 0, "R6");

    // R1 load and start together while idle: old length applies
    set_mode(5'b00001);
    @(negedge clk_i); mrs_i = 1'b1; mode_i = 5'b00011; start_i = 1'b1; col_i = COL_W'(1);
    @(negedge clk_i); mrs_i = 1'b0; start_i = 1'b0;
    beat(1, 1'b0, "R1");
    @(negedge clk_i); beat(0, 1'b1, "R1");
    @(negedge clk_i); chk(valid_o === 1'b0, "R1", int'(valid_o), 0);
    run_burst(0, 1, 8, 0, "R1");

    // R8 abort mid burst
    @(negedge clk_i); start_i = 1'b1; col_i = COL_W'(10);
    @(negedge clk_i); start_i = 1'b0;
    beat(10, 1'b0, "R8");
    @(negedge clk_i); beat(11, 1'b0, "R8");
    start_i = 1'b1; col_i = COL_W'(21);
    @(negedge clk_i); start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      beat(exp_col(21, i, 8, 0), i == 7, "R8");
      @(negedge clk_i);
    end
    chk(valid_o === 1'b0, "R8", int'(valid_o), 0);

    // R8 restart on the final beat: no gap
    set_mode(5'b00010);
    @(negedge clk_i); start_i = 1'b1; col_i = COL_W'(0);
    @(negedge clk_i); start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      beat(i, i == 3, "R8");
      if (i == 3) begin start_i = 1'b1; col_i = COL_W'(6); end
      @(negedge clk_i);
      start_i = 1'b0;
    end
    for (int i = 0; i < 4; i++) begin
      beat(exp_col(6, i, 4, 0), i == 3, "R8");
      @(negedge clk_i);
    end
    chk(valid_o === 1'b0, "R8", int'(valid_o), 0);

    // R9 refused load during burst
    set_mode(5'b00011);
    @(negedge clk_i); start_i = 1'b1; col_i = COL_W'(3);
    @(negedge clk_i); start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      beat(exp_col(3, i, 8, 0), i == 7, "R9");
      if (i == 3) chk(mrs_err_o === 1'b1, "R9", int'(mrs_err_o), 1);
      if (i == 4) chk(mrs_err_o === 1'b0, "R9", int'(mrs_err_o), 0);
      if (i == 2) begin mrs_i = 1'b1; mode_i = 5'b00100; end
      @(negedge clk_i);
      mrs_i = 1'b0;
    end
    chk(mode_err_o === 1'b0, "R9", int'(mode_err_o), 0);
    run_burst(0, 5, 8, 0, "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule